// File: doc/BRIEF.md
# RAM-Backed Programmable Delay Line

This block delays a stream of data words by a selectable number of accepted beats, from zero up to one less than the storage depth. The default depth is 64, which gives delays of 0 to 63. The words are not moved through a chain of registers. Each word is written once into a small register-file memory. A write address steps through the memory, and the read address trails it by the programmed distance. Each accepted beat stores one new word and presents one delayed word.

The stream side uses a valid/ready handshake with a single rule. A beat takes place when the upstream offers a word (`in_valid`) and the downstream can take one (`out_ready`) in the same cycle. Back-pressure passes straight through: `in_ready` follows `out_ready`, and `out_valid` follows `in_valid`. No words are buffered at the edge, so a stall on either side freezes the line. A setting of zero skips the memory and sends the input word to the output in the same cycle. The delay setting is a plain control input. It is registered on every clock and may change in mid-stream. When it changes, the output jumps to the word that sits at the new distance in the history, so words can be skipped or repeated.

Top module: `ram_delay_line`

## Requirements
- R1: `in_ready` equals `out_ready` and `out_valid` equals `in_valid` in every cycle. A beat is a cycle in which `in_valid` and `out_ready` are both 1.
- R2: With an active delay d in 1..63, on beat number k after reset (counting from 0) with k >= d, `out_data` equals the word accepted on beat k-d.
- R3: With an active delay of 0, `out_data` equals `in_data` in the same cycle.
- R4: With an active delay d > 0, every beat k < d after reset outputs all-zero `out_data`.
- R5: A cycle without a beat changes neither the stored history nor the beat count, so gaps of any length leave the delayed sequence intact.
- R6: `dly_sel` is captured at every rising clock edge and governs every beat after that edge. After a change, the output follows R2/R4 using the new delay and the full beat history. Reset sets the captured delay to 0.
- R7: The memory keeps the 63 most recent words across address wraparound, so delay 63 stays correct well beyond 64 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream offers a word |
| in_ready | output | 1 | Line can accept a word (follows out_ready) |
| in_data | input | DATA_W | Input word |
| dly_sel | input | log2(DEPTH) | Requested delay in beats |
| out_valid | output | 1 | Delayed word is presented (follows in_valid) |
| out_ready | input | 1 | Downstream can take a word |
| out_data | output | DATA_W | Delayed word |

## Verification
The assertions check on every cycle that the write address steps by exactly one per beat and holds across stalls. They also check that the word written on a beat is in memory on the next cycle, that a zero delay passes the input through, and that once the history covers the delay it never falls back to zero output unless the delay grows. Whether each output word is the right one from the past only shows up through the bench's scenarios. These sweep every delay setting with irregular stalls from both sides, run past the address wraparound, and change the delay in mid-stream against an arithmetic model of the history.

// File: rtl/dl_pkg.sv
package dl_pkg;
  // Source of the word presented at the output.
  typedef enum logic [1:0] {
    SRC_BYPASS = 2'd0,
    SRC_ZERO   = 2'd1,
    SRC_RAM    = 2'd2
  } src_e;
endpackage

// File: rtl/dl_ptr_ctrl.sv
module dl_ptr_ctrl #(
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [ADDR_W-1:0] dly_in,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] dly_act,
  output dl_pkg::src_e      src
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] wr_q;
  logic [ADDR_W-1:0] fill_q;
  logic [ADDR_W-1:0] dly_q;

  // Delay setting is captured every cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_in;
  end

  // Write address starts on the last entry and circulates.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wr_q <= LAST;
    else if (beat) wr_q <= ADDR_W'(wr_q + 1'b1);
  end

  // Count of stored words, saturating at the largest delay.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      fill_q <= '0;
    else if (beat && fill_q != LAST) fill_q <= ADDR_W'(fill_q + 1'b1);
  end

  always_comb begin
    wr_addr = wr_q;
    rd_addr = ADDR_W'(wr_q - dly_q);
    dly_act = dly_q;
    if (dly_q == '0)        src = dl_pkg::SRC_BYPASS;
    else if (fill_q < dly_q) src = dl_pkg::SRC_ZERO;
    else                    src = dl_pkg::SRC_RAM;
  end

  // R2
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> wr_q == ADDR_W'($past(wr_q) + 1'b1));

  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> ($stable(wr_q) && $stable(fill_q)));

  // R4
  fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && src == dl_pkg::SRC_RAM) |=>
      (src != dl_pkg::SRC_ZERO || dly_q > $past(dly_q)));
endmodule

// File: rtl/dl_ram.sv
module dl_ram #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

  // R2
  ram_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/dl_out_sel.sv
module dl_out_sel #(
  parameter int DATA_W = 16
) (
  input  dl_pkg::src_e      src,
  input  logic [DATA_W-1:0] in_data,
  input  logic [DATA_W-1:0] ram_data,
  output logic [DATA_W-1:0] out_data
);
  always_comb begin
    unique case (src)
      dl_pkg::SRC_BYPASS: out_data = in_data;
      dl_pkg::SRC_RAM:    out_data = ram_data;
      default:            out_data = '0;
    endcase
  end
endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [ADDR_W-1:0] dly_sel,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              beat;
  logic [ADDR_W-1:0] wr_addr;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] dly_act;
  logic [DATA_W-1:0] ram_data;
  dl_pkg::src_e      src;

  assign in_ready  = out_ready;
  assign out_valid = in_valid;
  assign beat      = in_valid & out_ready;

  dl_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .dly_in(dly_sel),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .dly_act(dly_act), .src(src)
  );

  dl_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst_n(rst_n), .we(beat), .waddr(wr_addr),
    .wdata(in_data), .raddr(rd_addr), .rdata(ram_data)
  );

  dl_out_sel #(.DATA_W(DATA_W)) u_sel (
    .src(src), .in_data(in_data), .ram_data(ram_data), .out_data(out_data)
  );

  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && dly_act == '0) |-> out_data == in_data);

  // R6
  dly_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> dly_act == $past(dly_sel));
endmodule

// File: tb/sim_ram_delay_line.sv
module sim_ram_delay_line;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, out_valid, out_ready;
  logic [15:0] in_data, out_data;
  logic [5:0]  dly_sel;

  always #2 clk = ~clk;

  ram_delay_line #(.DATA_W(16), .DEPTH(64)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .dly_sel(dly_sel), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] hist [0:255];
  int nh = 0;
  int act_d = 0;
  bit prev_stall = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] val(input int d, input int k);
    return 16'((d * 40503 + k * 2654 + 17) ^ (k << 9)) | 16'h0001;
  endfunction

  task automatic step(input logic iv, input logic ordy, input logic [15:0] din,
                      input int dsel, input string force_tag);
    logic [15:0] exp;
    string tag;
    bit b;
    @(negedge clk);
    in_valid = iv; out_ready = ordy; in_data = din; dly_sel = 6'(dsel);
    #1;
    chk("R1 ready", 32'(in_ready), 32'(ordy));
    chk("R1 valid", 32'(out_valid), 32'(iv));
    b = iv && ordy;
    if (b) begin
      if (act_d == 0) begin exp = din; tag = "R3"; end
      else if (nh >= act_d) begin
        exp = hist[nh - act_d];
        tag = (nh >= 64) ? "R7" : (prev_stall ? "R5" : "R2");
      end else begin exp = 16'h0; tag = "R4"; end
      if (force_tag != "") tag = force_tag;
      chk(tag, 32'(out_data), 32'(exp));
    end
    @(posedge clk);
    act_d = dsel;
    if (b) begin hist[nh] = din; nh++; end
    prev_stall = !b;
  endtask

  task automatic reset_dut(input int d);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0; dly_sel = 6'(d);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nh = 0; act_d = 0; prev_stall = 1'b0;
    step(1'b0, 1'b1, 16'h0, d, "R1");
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0; dly_sel = '0;
    // Exhaustive sweep of every delay with stalls on both sides (R2..R5, R7).
    for (int d = 0; d < 64; d++) begin
      int c = 0;
      reset_dut(d);
      while (nh < d + 12) begin
        logic iv, ordy;
        iv   = (c % 7) != 6;
        ordy = ((c + d) % 5) != 4;
        step(iv, ordy, val(d, nh), d, "");
        c++;
      end
    end
    // Mid-stream delay changes (R6).
    reset_dut(10);
    for (int i = 0; i < 30; i++) step(1'b1, 1'b1, val(99, nh), 10, "R6");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1, val(99, nh), 3, "R6");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b1, val(99, nh), 40, "R6");
    for (int i = 0; i < 3; i++)  step(1'b1, 1'b1, val(99, nh), 0, "R6");
    for (int i = 0; i < 70; i++) step(i % 9 != 4, 1'b1, val(99, nh), 63, "R6");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule